// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches a synchronized parallel input vector and raises an active-low interrupt request when the vector no longer matches a stored reference snapshot. The interrupt is modelled as an output enable: when `int_oe_o` is high, the pad driver pulls the shared interrupt line low, and when it is low the line is released. If the pins go back to the snapshot value, the request is withdrawn without any bus traffic.

The bus controller that sits beside this block supplies qualifiers and one-cycle strobes:

- `sel_i` marks a transfer that addresses this device.
- `ack_i` marks the acknowledge bit period.
- `rnw_i` gives the transfer direction.
- `scl_rise_i` and `scl_fall_i` mark the serial clock edges.

A read clears the request and reloads the snapshot on the rising clock edge of the acknowledge bit. The snapshot then keeps tracking the pins for as long as that clock pulse stays high. A write clears and reloads on the falling clock edge of the acknowledge bit.

A pin change that happens during the acknowledge clock pulse is therefore lost or only briefly visible. This is intended behaviour.

The sequencer has four states:

- **INIT** is entered from reset and always leaves to WATCH after one cycle, loading the snapshot from the pins.
- **WATCH** is the compare state. It leaves to RD_HOLD on an addressed read acknowledge rising edge, and to WR_PEND on an addressed write acknowledge rising edge.
- **RD_HOLD** keeps the request released while the snapshot follows the pins. It returns to WATCH on an addressed falling edge, or when the selection drops.
- **WR_PEND** keeps comparing. It returns to WATCH with a reload on an addressed falling edge, or without a reload when the selection drops.

Top module: `pin_change_irq`

## Requirements
- R1: While reset is applied, `int_oe_o` is 0. In the first cycle after reset the snapshot is loaded from `pins_i`, so no interrupt results from the pin value present at reset.
- R2: In WATCH, any bit of `pins_i` that differs from the snapshot makes `int_oe_o` 1 from the clock edge that samples the differing value.
- R3: When `pins_i` returns to the snapshot value, `int_oe_o` goes back to 0 at the edge that samples it, with no bus access.
- R4: On the edge that samples `sel_i=1`, `ack_i=1`, `rnw_i=1` and `scl_rise_i=1` in WATCH, `int_oe_o` becomes 0 and the snapshot takes the sampled `pins_i`.
- R5: After an addressed write acknowledge rising edge (`rnw_i=0`), comparing continues. On the edge that samples `sel_i=1` with `scl_fall_i=1`, `int_oe_o` becomes 0 and the snapshot takes `pins_i`.
- R6: Strobes received with `sel_i=0` change neither the snapshot nor `int_oe_o`.
- R7: While the read acknowledge pulse is high (RD_HOLD), `int_oe_o` stays 0 and the snapshot follows `pins_i`. A pin change in that window does not raise an interrupt afterwards.
- R8: After any clear, a new difference between the pins and the snapshot raises `int_oe_o` again.
- R9: A `scl_rise_i` strobe with `sel_i=1` but `ack_i=0` does not clear the interrupt.
- R10: If `sel_i` drops while a write acknowledge is pending, the sequencer returns to WATCH without a reload, and a pending interrupt stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | WIDTH | Synchronized port pin values |
| sel_i | input | 1 | Current transfer addresses this device |
| ack_i | input | 1 | Acknowledge bit period of the transfer |
| rnw_i | input | 1 | Transfer direction, 1 = read |
| scl_rise_i | input | 1 | One-cycle strobe on a serial clock rising edge |
| scl_fall_i | input | 1 | One-cycle strobe on a serial clock falling edge |
| int_oe_o | output | 1 | Interrupt pull-down enable, 1 = line driven low |

## Verification
A snapshot holding a wrong value shows up as an interrupt that is raised, or missing, on the cycle after the next pin sample. It therefore surfaces within one clock of a pin pattern that exposes the bad bit. A sequencer left in RD_HOLD suppresses every later interrupt, and one that skips WR_PEND clears one acknowledge edge early. Both are visible at `int_oe_o` on the cycle after the relevant strobe. The bench uses directed acknowledge sequences and random pin traffic, so that every such fault reaches the output within one cycle of the stimulus that exercises it.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;
    typedef enum logic [1:0] {
        ST_INIT    = 2'd0,
        ST_WATCH   = 2'd1,
        ST_RD_HOLD = 2'd2,
        ST_WR_PEND = 2'd3
    } seq_state_e;
endpackage

// File: rtl/pci_seq.sv
module pci_seq
    import pin_change_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic       ack_i,
    input  logic       rnw_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    output seq_state_e state_o,
    output logic       load_o,
    output logic       cmp_o
);
    seq_state_e st_q, st_d;
    logic rd_hit, wr_hit, ack_end;

    assign rd_hit  = sel_i & ack_i & scl_rise_i & rnw_i;
    assign wr_hit  = sel_i & ack_i & scl_rise_i & ~rnw_i;
    assign ack_end = sel_i & scl_fall_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_INIT;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_INIT:    st_d = ST_WATCH;
            ST_WATCH: begin
                if (rd_hit)      st_d = ST_RD_HOLD;
                else if (wr_hit) st_d = ST_WR_PEND;
            end
            ST_RD_HOLD: if (!sel_i || ack_end) st_d = ST_WATCH;
            ST_WR_PEND: if (!sel_i || ack_end) st_d = ST_WATCH;
            default:    st_d = ST_INIT;
        endcase
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        unique case (st_q)
            ST_INIT:    load_o = 1'b1;
            ST_WATCH:   load_o = rd_hit;
            ST_RD_HOLD: load_o = sel_i;
            ST_WR_PEND: load_o = ack_end;
            default:    load_o = 1'b0;
        endcase
        cmp_o = (st_d == ST_WATCH) || (st_d == ST_WR_PEND);
    end

    assign state_o = st_q;
endmodule

// File: rtl/pci_snapshot.sv
module pci_snapshot #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] snap_d_o,
    output logic [WIDTH-1:0] snap_q_o
);
    logic [WIDTH-1:0] snap_q;

    // next snapshot value, shared with the compare stage
    assign snap_d_o = load_i ? pins_i : snap_q;

    // pins idle high, so the reset value is all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '1;
        else        snap_q <= snap_d_o;
    end

    assign snap_q_o = snap_q;
endmodule

// File: rtl/pci_flag.sv
module pci_flag #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_i,
    input  logic [WIDTH-1:0] pins_i,
    input  logic [WIDTH-1:0] snap_i,
    output logic             int_o
);
    logic [WIDTH-1:0] bit_diff;
    logic             int_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_diff
        assign bit_diff[g] = pins_i[g] ^ snap_i[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_q <= 1'b0;
        else        int_q <= cmp_i & (|bit_diff);
    end

    assign int_o = int_q;
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
    import pin_change_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    input  logic             sel_i,
    input  logic             ack_i,
    input  logic             rnw_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    output logic             int_oe_o
);
    seq_state_e       state_q;
    logic             load_en, cmp_en;
    logic [WIDTH-1:0] snap_d, snap_q;

    pci_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_i),
        .ack_i      (ack_i),
        .rnw_i      (rnw_i),
        .scl_rise_i (scl_rise_i),
        .scl_fall_i (scl_fall_i),
        .state_o    (state_q),
        .load_o     (load_en),
        .cmp_o      (cmp_en)
    );

    pci_snapshot #(.WIDTH(WIDTH)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_en),
        .pins_i   (pins_i),
        .snap_d_o (snap_d),
        .snap_q_o (snap_q)
    );

    pci_flag #(.WIDTH(WIDTH)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_i  (cmp_en),
        .pins_i (pins_i),
        .snap_i (snap_d),
        .int_o  (int_oe_o)
    );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk
    import pin_change_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] pins_i,
    input logic             sel_i,
    input logic             ack_i,
    input logic             rnw_i,
    input logic             scl_rise_i,
    input logic             scl_fall_i,
    input logic             int_oe_o,
    input seq_state_e       state_q,
    input logic [WIDTH-1:0] snap_q
);
    always_comb begin
        if (!rst_n) assert_reset_release_R1: assert (!int_oe_o);
    end

    assert_init_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |=> (!int_oe_o && snap_q == $past(pins_i)));

    assert_flag_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_oe_o |-> ($past(pins_i) != snap_q));

    assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WATCH && sel_i && ack_i && rnw_i && scl_rise_i)
        |=> (!int_oe_o && snap_q == $past(pins_i)));

    assert_write_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_PEND && sel_i && scl_fall_i) |=> !int_oe_o);

    assert_foreign_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_i && state_q != ST_INIT) |=> $stable(snap_q));

    assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_HOLD) |-> !int_oe_o);
endmodule

bind pin_change_irq pin_change_irq_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_i     (pins_i),
    .sel_i      (sel_i),
    .ack_i      (ack_i),
    .rnw_i      (rnw_i),
    .scl_rise_i (scl_rise_i),
    .scl_fall_i (scl_fall_i),
    .int_oe_o   (int_oe_o),
    .state_q    (state_q),
    .snap_q     (snap_q)
);

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pins = 8'hA5;
    logic         sel = 0, ack = 0, rnw = 0, rise = 0, fall = 0;
    logic         int_oe;
    int           errors = 0, checks = 0;
    logic [W-1:0] snap_m;

    always #2 clk = ~clk;

    pin_change_irq #(.WIDTH(W)) u_pin_change_irq (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .sel_i(sel), .ack_i(ack),
        .rnw_i(rnw), .scl_rise_i(rise), .scl_fall_i(fall), .int_oe_o(int_oe)
    );

    function automatic logic exp_flag(logic [W-1:0] p, logic [W-1:0] s);
        return p != s;
    endfunction

    task automatic cyc(input logic [W-1:0] p, input logic s, input logic a,
                       input logic r, input logic ri, input logic fa);
        @(negedge clk);
        pins = p; sel = s; ack = a; rnw = r; rise = ri; fall = fa;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic exp, input string req);
        checks++;
        if (int_oe !== exp) begin
            errors++;
            $display("FAIL %s: int_oe=%0b expected %0b", req, int_oe, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1 chk(1'b0, "R1 during reset");
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        cyc(8'hA5, 0, 0, 0, 0, 0); chk(1'b0, "R1 first cycle");
        cyc(8'hA5, 0, 0, 0, 0, 0); chk(1'b0, "R1 no spurious");
        cyc(8'hA4, 0, 0, 0, 0, 0); chk(1'b1, "R2 bit0 fall");
        cyc(8'hA5, 0, 0, 0, 0, 0); chk(1'b0, "R3 return");
        cyc(8'h25, 0, 0, 0, 0, 0); chk(1'b1, "R2 bit7 fall");
        cyc(8'h25, 0, 1, 1, 1, 0); chk(1'b1, "R6 foreign read rise");
        cyc(8'h25, 0, 1, 0, 0, 1); chk(1'b1, "R6 foreign fall");
        cyc(8'h25, 1, 0, 1, 1, 0); chk(1'b1, "R9 rise outside ack");
        cyc(8'h25, 1, 0, 1, 0, 1); chk(1'b1, "R9 fall outside ack");
        // read acknowledge: clear on rising edge
        cyc(8'h25, 1, 1, 1, 1, 0); chk(1'b0, "R4 read clear");
        cyc(8'h26, 1, 1, 1, 0, 0); chk(1'b0, "R7 change in pulse");
        cyc(8'h26, 1, 1, 1, 0, 1); chk(1'b0, "R7 fall");
        cyc(8'h26, 0, 0, 0, 0, 0); chk(1'b0, "R7 swallowed");
        cyc(8'h27, 0, 0, 0, 0, 0); chk(1'b1, "R8 after read clear");
        // write acknowledge: clear on falling edge
        cyc(8'h27, 1, 1, 0, 1, 0); chk(1'b1, "R5 no clear at rise");
        cyc(8'h27, 1, 1, 0, 0, 0); chk(1'b1, "R5 pending");
        cyc(8'h07, 1, 1, 0, 0, 1); chk(1'b0, "R5 write clear");
        cyc(8'h07, 0, 0, 0, 0, 0); chk(1'b0, "R5 snapshot reloaded");
        cyc(8'h87, 0, 0, 0, 0, 0); chk(1'b1, "R8 after write clear");
        cyc(8'h07, 0, 0, 0, 0, 0); chk(1'b0, "R3 return again");
        // change inside write pulse is brief
        cyc(8'h07, 1, 1, 0, 1, 0); chk(1'b0, "R5 rise no diff");
        cyc(8'h0F, 1, 1, 0, 0, 0); chk(1'b1, "R5 brief flag");
        cyc(8'h0F, 1, 1, 0, 0, 1); chk(1'b0, "R5 brief cleared");
        // abandoned write
        cyc(8'h0F, 1, 1, 0, 1, 0); chk(1'b0, "R10 rise");
        cyc(8'h1F, 1, 1, 0, 0, 0); chk(1'b1, "R10 change");
        cyc(8'h1F, 0, 0, 0, 0, 0); chk(1'b1, "R10 deselect");
        cyc(8'h1F, 0, 0, 0, 0, 1); chk(1'b1, "R10 stray fall");
        cyc(8'h0F, 0, 0, 0, 0, 0); chk(1'b0, "R10 snapshot kept");

        // random phase
        snap_m = 8'h0F;
        void'($urandom(32'd12345));
        for (int i = 0; i < 600; i++) begin
            int op;
            logic [W-1:0] p;
            op = $urandom_range(0, 9);
            p  = pins ^ W'($urandom_range(0, 255) & $urandom_range(0, 255));
            if (op < 6) begin
                cyc(p, 0, 0, 0, 0, 0); chk(exp_flag(p, snap_m), "R2/R3 random pins");
            end else if (op == 6) begin
                cyc(p, 0, 1, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
                chk(exp_flag(p, snap_m), "R6 random foreign");
            end else if (op == 7) begin
                cyc(p, 1, 1, 1, 1, 0); snap_m = p; chk(1'b0, "R4 random read");
                p = p ^ W'($urandom_range(0, 255));
                cyc(p, 1, 1, 1, 0, 0); snap_m = p; chk(1'b0, "R7 random hold");
                cyc(p, 1, 1, 1, 0, 1); snap_m = p; chk(1'b0, "R7 random fall");
            end else begin
                cyc(p, 1, 1, 0, 1, 0); chk(exp_flag(p, snap_m), "R5 random write rise");
                p = p ^ W'($urandom_range(0, 255));
                cyc(p, 1, 1, 0, 0, 1); snap_m = p; chk(1'b0, "R5 random write fall");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule